// File: doc/BRIEF.md
# At-Speed Capture Clock Gate

This block sits on the clock path between a fast on-chip clock source and the clock trees of logic under scan test. During scan shift it hands the logic a slow clock supplied by the tester. When scan enable drops for capture, it instead emits a short, exactly counted burst of fast-clock pulses. A launch pulse followed by a capture pulse at full speed is what transition-fault testing needs.

Each pattern picks which pulse slots of the capture window fire. A small serial clock chain holds that choice. It is clocked by the slow clock and loaded while scan enable is high, so the choice of slots travels with the scan data. Scan enable is brought into the fast domain through two flops before a burst may start. The two clock sources are switched by a handshake, so the output never carries a runt pulse. A bypass control, or test mode being low, sends the fast clock straight through for functional operation.

Top module: `atspeed_clk_gate`

## Requirements
- R1: With test_mode low, clk_out is fast_clk, whatever the values of scan_en, bypass and chain_si.
- R2: With test_mode high and bypass high, clk_out is fast_clk.
- R3: In test mode with scan_en high, once the handover has completed, clk_out gives exactly one rising edge for each rising edge of slow_clk and no fast pulses.
- R4: On each rising slow_clk edge while test_mode and scan_en are both high, the chain shifts one place toward its top: chain_si enters bit 0 and chain_so shows the top bit (bit CHAIN_LEN-1). A word P is therefore loaded by presenting P[CHAIN_LEN-1] first and P[0] last.
- R5: While scan_en is low the chain does not change. After a capture, the bits shifted out on chain_so are the word loaded before it, top bit first.
- R6: After scan_en falls, the capture window starts only once the falling edge has passed two fast_clk flops and the slow enable has been seen off. The window then has MAX_PULSES slots on consecutive fast_clk cycles, and slot i gives one pulse exactly when chain bit i is 1. Chain bits at or above MAX_PULSES select no slot.
- R7: Pulses in enabled slots i and j are spaced by (j - i) fast_clk periods, so adjacent enabled slots give a launch and a capture one fast period apart.
- R8: After the last slot, clk_out stays low until scan_en rises again. The slow clock is re-enabled only after the fast side has gone back to idle.
- R9: The slow and fast gating enables are never active together.
- R10: In reset, clk_out is low in test mode without bypass, and the chain resets to slots 0 and 1 enabled with all other bits 0. A capture straight out of reset therefore gives two back-to-back pulses.
- R11: A chain word with no enabled slot gives a capture window with no pulse at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast source clock used for the capture pulses and for bypass |
| slow_clk | input | 1 | Tester shift clock, which also clocks the chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | High selects scan operation, low gives the functional fast clock |
| bypass | input | 1 | High in test mode passes fast_clk straight through |
| scan_en | input | 1 | High for shift, low for the capture window |
| chain_si | input | 1 | Serial input to the slot-select chain |
| chain_so | output | 1 | Serial output, the top bit of the chain |
| clk_out | output | 1 | Gated clock sent to the logic under test |

## Verification
The assertions check on every cycle the parts of the handover that live inside the block. The two gating enables never overlap. A burst begins only after both synchronised views show shift is over. The fast enable stays off once the window has closed. The chain holds while scan enable is low. Pulse counts, slot spacing measured in fast periods, the bit order of the chain, and clock pass-through in bypass and functional mode are seen only at the output pins, so they rest on the bench's directed and random patterns. Each pattern is followed by a readback of the chain after capture.

// File: rtl/atspeed_clk_gate.sv
module atspeed_clk_gate #(
  parameter int CHAIN_LEN  = 5,
  parameter int MAX_PULSES = 4
) (
  input  logic fast_clk,
  input  logic slow_clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic bypass,
  input  logic scan_en,
  input  logic chain_si,
  output logic chain_so,
  output logic clk_out
);

  localparam int SW = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;
  localparam logic [CHAIN_LEN-1:0] CHAIN_RST = CHAIN_LEN'(3);
  localparam logic [SW-1:0] LAST_SLOT = SW'(MAX_PULSES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_DONE} st_t;

  logic [CHAIN_LEN-1:0] chain;
  logic [SW-1:0]        slot;
  st_t                  st;
  logic se_s1, se_s2, so_s1, so_s2;
  logic fi_s1, fi_s2;
  logic fast_en, slow_en;
  logic gated;

  // slot-select chain, slow domain
  always_ff @(posedge slow_clk or negedge rst_n)
    if (!rst_n)                   chain <= CHAIN_RST;
    else if (test_mode && scan_en) chain <= {chain[CHAIN_LEN-2:0], chain_si};

  assign chain_so = chain[CHAIN_LEN-1];

  // fast domain: synchronisers and burst sequencer
  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n) begin
      se_s1 <= 1'b0;
      se_s2 <= 1'b0;
      so_s1 <= 1'b0;
      so_s2 <= 1'b0;
      st    <= ST_IDLE;
      slot  <= '0;
    end else begin
      se_s1 <= scan_en;
      se_s2 <= se_s1;
      so_s1 <= slow_en;
      so_s2 <= so_s1;
      unique case (st)
        ST_IDLE:  if (test_mode && !se_s2 && !so_s2) begin
                    st   <= ST_BURST;
                    slot <= '0;
                  end
        ST_BURST: if (slot == LAST_SLOT) st <= ST_DONE;
                  else                   slot <= slot + 1'b1;
        ST_DONE:  if (se_s2) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end

  always_ff @(negedge fast_clk or negedge rst_n)
    if (!rst_n) fast_en <= 1'b0;
    else        fast_en <= test_mode && (st == ST_BURST) && chain[slot];

  // slow domain: wait for fast side idle before re-enabling
  always_ff @(posedge slow_clk or negedge rst_n)
    if (!rst_n) begin
      fi_s1 <= 1'b0;
      fi_s2 <= 1'b0;
    end else begin
      fi_s1 <= (st == ST_IDLE);
      fi_s2 <= fi_s1;
    end

  always_ff @(negedge slow_clk or negedge rst_n)
    if (!rst_n) slow_en <= 1'b0;
    else        slow_en <= test_mode && scan_en && fi_s2;

  assign gated   = (slow_clk & slow_en) | (fast_clk & fast_en);
  assign clk_out = (!test_mode || bypass) ? fast_clk : gated;

  // R9
  one_source_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    !(fast_en && slow_en));

  // R6
  burst_after_sync_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (st == ST_BURST && $past(st) == ST_IDLE) |-> (!$past(se_s2) && !$past(so_s2)));

  // R8
  quiet_after_burst_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (st == ST_DONE && $past(st) == ST_DONE) |-> !fast_en);

  // R5
  chain_hold_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    !scan_en |=> $stable(chain));

  // R8
  slow_waits_idle_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (st == ST_BURST) |-> !so_s2);

endmodule

// File: tb/atspeed_clk_gate_bench.sv
module atspeed_clk_gate_bench;
  localparam int CL = 5;
  localparam int MP = 4;

  logic fast_clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic test_mode = 1'b1, bypass = 1'b0, scan_en = 1'b0, chain_si = 1'b0;
  logic chain_so, clk_out;

  int checks = 0, fails = 0;
  bit rec = 1'b0;
  int pcount = 0;
  time ptimes [8];

  atspeed_clk_gate #(.CHAIN_LEN(CL), .MAX_PULSES(MP)) u_atspeed_clk_gate (
    .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .test_mode(test_mode), .bypass(bypass), .scan_en(scan_en),
    .chain_si(chain_si), .chain_so(chain_so), .clk_out(clk_out));

  initial begin #1; forever #5 fast_clk = ~fast_clk; end
  initial forever #20 slow_clk = ~slow_clk;

  always @(posedge clk_out) if (rec) begin
    if (pcount < 8) ptimes[pcount] = $time;
    pcount++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int exp_pulses(input logic [CL-1:0] pat);
    int n = 0;
    for (int i = 0; i < MP; i++) if (pat[i]) n++;
    return n;
  endfunction

  task automatic check_burst(input logic [CL-1:0] pat);
    int slots [MP];
    int n = 0;
    for (int i = 0; i < MP; i++) if (pat[i]) begin slots[n] = i; n++; end
    // R6 R11: pulse count equals enabled slots
    check(pcount == n, "R6/R11 pulse count", pcount, n);
    // R7: spacing in fast periods
    if (pcount == n)
      for (int j = 1; j < n; j++)
        check(ptimes[j] - ptimes[0] == 10 * (slots[j] - slots[0]), "R7 pulse spacing",
              ptimes[j] - ptimes[0], 10 * (slots[j] - slots[0]));
  endtask

  task automatic shift_cycle(input logic b);
    chain_si = b;
    @(posedge slow_clk); #5;
  endtask

  // read back old word while flushing, then load new word and count slow edges
  task automatic load(input logic [CL-1:0] nw, input logic [CL-1:0] old);
    scan_en = 1'b1;
    for (int k = 0; k < CL; k++) begin
      check(chain_so == old[CL-1-k], "R4/R5 chain readback", chain_so, old[CL-1-k]);
      shift_cycle(1'b0);
    end
    pcount = 0; rec = 1'b1;
    for (int k = CL - 1; k >= 0; k--) shift_cycle(nw[k]);
    rec = 1'b0;
    check(pcount == CL, "R3 one edge per slow edge", pcount, CL);
  endtask

  task automatic capture(input logic [CL-1:0] pat);
    pcount = 0; rec = 1'b1;
    scan_en = 1'b0;
    repeat (20) @(posedge slow_clk);
    #5; rec = 1'b0;
    // R8: total over a long window shows no extra pulse after the burst
    check(pcount == exp_pulses(pat), "R8 quiet after burst", pcount, exp_pulses(pat));
    check_burst(pat);
  endtask

  task automatic window_fast(input string req);
    pcount = 0; rec = 1'b1;
    repeat (8) @(posedge slow_clk);
    #5; rec = 1'b0;
    check(pcount == 32, req, pcount, 32);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [CL-1:0] cur, pat;
    logic [CL-1:0] dir [4];
    dir[0] = 5'b00000; dir[1] = 5'b01111; dir[2] = 5'b01001; dir[3] = 5'b10100;
    void'($urandom(77));
    rec = 1'b1;
    #3;
    // R10: reset state
    check(clk_out == 1'b0, "R10 clk_out low in reset", clk_out, 0);
    check(chain_so == 1'b0, "R10 chain top bit reset", chain_so, 0);
    @(posedge slow_clk); @(posedge slow_clk); #5;
    rst_n = 1'b1;
    pcount = 0;
    repeat (20) @(posedge slow_clk);
    #5; rec = 1'b0;
    // R10: default word gives launch and capture
    check(pcount == 2, "R10 default pulse count", pcount, 2);
    check_burst(5'b00011);
    cur = 5'b00011;
    for (int r = 0; r < 4; r++) begin
      load(dir[r], cur); capture(dir[r]); cur = dir[r];
    end
    for (int r = 0; r < 6; r++) begin
      pat = CL'($urandom);
      load(pat, cur); capture(pat); cur = pat;
    end
    load(5'b00000, cur);
    // R2: bypass
    bypass = 1'b1;
    window_fast("R2 bypass passes fast clock");
    bypass = 1'b0;
    // R1: functional mode ignores scan controls
    test_mode = 1'b0; scan_en = 1'b1; chain_si = 1'b1;
    window_fast("R1 functional with scan_en high");
    scan_en = 1'b0; bypass = 1'b1;
    window_fast("R1 functional with scan_en low");
    finish_run();
  end
endmodule